// File: doc/BRIEF.md
# HDLC Receive Frame Status Checker

This block follows the flag-removal and bit-destuffing stage of an HDLC receiver. It tracks one frame at a time, from the opening flag to the closing flag. It counts the payload bits that arrive. At frame end it produces one status byte that says whether the frame was good. A frame is good only when its length is a whole number of octets and the CRC check agrees. The CRC check is computed upstream and arrives here as a single match input.

The smallest frame worth reporting depends on four things: the address handling mode, the address width, whether CRC reception is on, and whether the 16-bit or the 32-bit CRC is in use. A frame with fewer complete octets than that minimum is dropped without any report. An overflow from the receive path anywhere inside the frame is remembered and shown in the status byte. That overflow also raises an interrupt pulse together with the status strobe. An abort indication discards the frame in progress.

Top module: `hdlc_rx_frame_status`

## Requirements
- R1: After reset, `stat_vld`, `ovf_irq` and `stat_byte` are all 0 and no frame is open.
- R2: When `rx_end` is sampled during an open frame that is long enough, `stat_vld` is high for exactly the one following cycle. The frame then closes. Status byte layout: bit 7 is the good-frame flag, bit 6 is overflow, bit 5 is CRC failure, bit 4 is a ragged length, and bits 3:0 are 0.
- R3: A bit count that is not a multiple of 8 (for example 25 bits) gives bit 4 = 1 and bit 7 = 0. Octets are counted as the whole octets received. A bit presented in the same cycle as `rx_end` is not counted.
- R4: With CRC reception on (`crc_off`=0), the minimum octet counts are as follows. Mode codes are `adr_mode` 00 = mode 0, 01 = mode 1, 10 = mode 2 and 11 = auto. With `crc32`=0: mode 0 needs 2; mode 1 needs 3; mode 2 or auto needs 3 with an 8-bit address (`adr_wide`=0) and 4 with a 16-bit address. With `crc32`=1, each of these needs two octets more.
- R5: With CRC reception off, the minimum is 2 octets for mode 2 or auto with `adr_wide`=1. It is 1 octet in every other case.
- R6: A frame below its minimum produces no `stat_vld` and no `ovf_irq`, even when an overflow occurred in it.
- R7: With CRC reception on, `crc_ok`=0 at frame end gives bit 5 = 1 and bit 7 = 0. With CRC reception off, `crc_ok` is ignored and bit 5 is 0.
- R8: An `rx_ovf` pulse in any cycle of an open frame, including the `rx_end` cycle, sets bit 6. It also raises `ovf_irq` in the same cycle as `stat_vld`. An `rx_ovf` pulse outside a frame has no effect.
- R9: The four mode inputs are captured when `rx_start` is seen. Changes to them during the frame do not affect that frame's result.
- R10: `rx_abort` (highest priority) closes the frame with no status and clears the counters and the overflow latch. A later `rx_end` without a new `rx_start` is ignored.
- R11: The counters and the overflow latch clear when the status is issued and on each `rx_start`. An `rx_start` inside an open frame restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Opening flag seen; opens or restarts a frame |
| rx_bit_vld | input | 1 | One destuffed payload bit received this cycle |
| rx_end | input | 1 | Closing flag seen |
| rx_abort | input | 1 | Abort sequence seen |
| rx_ovf | input | 1 | Receive data overflow in the path this cycle |
| crc_ok | input | 1 | CRC match result, valid with `rx_end` |
| adr_mode | input | 2 | Address mode: 00 mode 0, 01 mode 1, 10 mode 2, 11 auto |
| adr_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| crc_off | input | 1 | 1 = CRC reception disabled |
| crc32 | input | 1 | 1 = 32-bit CRC, 0 = 16-bit CRC |
| stat_vld | output | 1 | One-cycle status strobe |
| stat_byte | output | 8 | Frame status byte |
| ovf_irq | output | 1 | Overflow interrupt pulse, together with the strobe |

## Verification
The assertions check the following on every cycle:
- the strobe is a single-cycle pulse that only follows a closing flag inside a frame;
- the interrupt never appears without the strobe and a set overflow bit;
- a ragged frame is never marked good;
- the captured mode stays still while the frame is open;
- the bit counter steps by one and clears when told to.

The minimum-length tables across every mode, address width and CRC choice can only be shown by the bench's scenarios. The same holds for the silent drop of short frames, the mid-frame mode change, and abort and restart.

// File: rtl/hdlc_rsc_pkg.sv
package hdlc_rsc_pkg;

  typedef enum logic [1:0] {
    ADR_M0   = 2'b00,
    ADR_M1   = 2'b01,
    ADR_M2   = 2'b10,
    ADR_AUTO = 2'b11
  } adr_mode_e;

  typedef struct packed {
    adr_mode_e mode;
    logic      wide;
    logic      crc_off;
    logic      crc32;
  } rx_cfg_t;

  typedef struct packed {
    logic       good;
    logic       ovf;
    logic       crc_bad;
    logic       ragged;
    logic [3:0] rsvd;
  } rx_stat_t;

  localparam int MIN_W = 3;

  // Address octets in front of the payload, per mode.
  function automatic logic [MIN_W-1:0] addr_octets(rx_cfg_t c);
    logic [MIN_W-1:0] n;
    unique case (c.mode)
      ADR_M0:           n = 3'd0;
      ADR_M1:           n = 3'd1;
      ADR_M2, ADR_AUTO: n = c.wide ? 3'd2 : 3'd1;
      default:          n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hdlc_rsc_bitcnt.sv
module hdlc_rsc_bitcnt #(
  parameter int CNT_W = 16,
  localparam int OCT_W = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [OCT_W-1:0] octets,
  output logic [2:0]       resid
);

  logic [CNT_W-1:0] bits_q;
  logic             sat;

  assign sat = &bits_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        bits_q <= '0;
    else if (inc && !sat)  bits_q <= bits_q + 1'b1;
  end

  assign octets = bits_q[CNT_W-1:3];
  assign resid  = bits_q[2:0];

  // R11: a clear request empties the counter on the next cycle
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bits_q == '0));

  // R3: each counted bit advances the count by one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !sat) |=> (bits_q == $past(bits_q) + 1'b1));

endmodule

// File: rtl/hdlc_rsc_minlen.sv
module hdlc_rsc_minlen
  import hdlc_rsc_pkg::*;
#(
  parameter int OCT_W = 13
) (
  input  rx_cfg_t          cfg,
  input  logic [OCT_W-1:0] octets,
  output logic             long_enough
);

  logic [MIN_W-1:0] need;
  logic [MIN_W-1:0] crc_oct;

  always_comb begin
    crc_oct = cfg.crc32 ? 3'd4 : 3'd2;
    if (cfg.crc_off) begin
      // Without CRC bytes: two octets only for a two-octet address, otherwise one
      need = (addr_octets(cfg) == 3'd2) ? 3'd2 : 3'd1;
    end else begin
      need = addr_octets(cfg) + crc_oct;
    end
  end

  generate
    if (OCT_W > MIN_W) begin : g_wide_cmp
      assign long_enough = (octets >= OCT_W'(need));
    end else begin : g_narrow_cmp
      assign long_enough = (MIN_W'(octets) >= need);
    end
  endgenerate

endmodule

// File: rtl/hdlc_rsc_ovf.sv
module hdlc_rsc_ovf (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic seen
);

  logic ovf_q;

  always_ff @(posedge clk) begin
    if (rst || clr) ovf_q <= 1'b0;
    else if (set)   ovf_q <= 1'b1;
  end

  assign seen = ovf_q;

  // R8: once set, the latch holds until a clear arrives
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);

endmodule

// File: rtl/hdlc_rx_frame_status.sv
module hdlc_rx_frame_status
  import hdlc_rsc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int OCT_W = CNT_W - 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_start,
  input  logic       rx_bit_vld,
  input  logic       rx_end,
  input  logic       rx_abort,
  input  logic       rx_ovf,
  input  logic       crc_ok,
  input  logic [1:0] adr_mode,
  input  logic       adr_wide,
  input  logic       crc_off,
  input  logic       crc32,
  output logic       stat_vld,
  output logic [7:0] stat_byte,
  output logic       ovf_irq
);

  logic             in_frame;
  rx_cfg_t          cfg_q;
  rx_stat_t         stat_q;
  logic             vld_q;
  logic             irq_q;
  logic             closing;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [OCT_W-1:0] octets;
  logic [2:0]       resid;
  logic             long_enough;
  logic             ovf_seen;
  logic             ovf_now;
  rx_stat_t         stat_d;

  assign closing = in_frame && rx_end && !rx_abort && !rx_start;
  assign cnt_clr = rx_abort || rx_start || closing;
  assign cnt_inc = in_frame && rx_bit_vld && !rx_end;

  hdlc_rsc_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .octets (octets),
    .resid  (resid)
  );

  hdlc_rsc_minlen #(.OCT_W(OCT_W)) u_min (
    .cfg         (cfg_q),
    .octets      (octets),
    .long_enough (long_enough)
  );

  hdlc_rsc_ovf u_ovf (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .set  (in_frame && rx_ovf),
    .seen (ovf_seen)
  );

  assign ovf_now = ovf_seen || rx_ovf;

  always_comb begin
    stat_d         = '0;
    stat_d.ragged  = (resid != 3'd0);
    stat_d.crc_bad = !cfg_q.crc_off && !crc_ok;
    stat_d.ovf     = ovf_now;
    stat_d.good    = !stat_d.ragged && !stat_d.crc_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cfg_q    <= '0;
      stat_q   <= '0;
      vld_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      irq_q <= 1'b0;
      if (rx_abort) begin
        in_frame <= 1'b0;
      end else if (rx_start) begin
        in_frame <= 1'b1;
        cfg_q    <= '{mode: adr_mode_e'(adr_mode), wide: adr_wide,
                      crc_off: crc_off, crc32: crc32};
      end else if (closing) begin
        in_frame <= 1'b0;
        if (long_enough) begin
          vld_q  <= 1'b1;
          stat_q <= stat_d;
          irq_q  <= ovf_now;
        end
      end
    end
  end

  assign stat_vld  = vld_q;
  assign stat_byte = stat_q;
  assign ovf_irq   = irq_q;

  // R2: the strobe lasts one cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    stat_vld |=> !stat_vld);

  // R2: the strobe only follows a closing flag inside a frame
  a_r2_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> ($past(rx_end) && $past(in_frame)));

  // R8: the interrupt rides on the strobe with the overflow bit set
  a_r8_irq_with_status: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (stat_vld && stat_byte[6]));

  // R3: a ragged frame is never good
  a_r3_ragged_not_good: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && stat_byte[4]) |-> !stat_byte[7]);

  // R9: the captured mode holds while the frame stays open
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !rx_start) |=> $stable(cfg_q));

  // R10: an abort never produces a status
  a_r10_abort_silent: assert property (@(posedge clk) disable iff (rst)
    rx_abort |=> !stat_vld);

endmodule

// File: tb/hdlc_rx_frame_status_tb.sv
module hdlc_rx_frame_status_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_start, rx_bit_vld, rx_end, rx_abort, rx_ovf, crc_ok;
  logic [1:0] adr_mode;
  logic       adr_wide, crc_off, crc32;
  logic       stat_vld, ovf_irq;
  logic [7:0] stat_byte;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_frame_status u_dut (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_bit_vld(rx_bit_vld),
    .rx_end(rx_end), .rx_abort(rx_abort), .rx_ovf(rx_ovf), .crc_ok(crc_ok),
    .adr_mode(adr_mode), .adr_wide(adr_wide), .crc_off(crc_off), .crc32(crc32),
    .stat_vld(stat_vld), .stat_byte(stat_byte), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_min(input logic [1:0] m, input logic w,
                                 input logic off, input logic c32);
    if (off) return (m[1] && w) ? 2 : 1;
    case (m)
      2'b00:   return c32 ? 4 : 2;
      2'b01:   return c32 ? 5 : 3;
      default: return w ? (c32 ? 6 : 4) : (c32 ? 5 : 3);
    endcase
  endfunction

  task automatic set_mode(input logic [1:0] m, input logic w,
                          input logic off, input logic c32);
    adr_mode = m; adr_wide = w; crc_off = off; crc32 = c32;
  endtask

  // Runs one frame and samples the result in the cycle after rx_end.
  task automatic run_frame(input int nbits, input logic crc_in, input int ovf_at,
                           input int flip_at, input int abort_at,
                           output logic vld, output logic [7:0] st, output logic irq);
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      rx_bit_vld = 1'b1;
      rx_ovf     = (i == ovf_at);
      rx_abort   = (i == abort_at);
      if (i == flip_at) begin
        adr_wide = ~adr_wide; crc32 = ~crc32; adr_mode = ~adr_mode;
      end
      @(negedge clk);
    end
    rx_bit_vld = 1'b0; rx_ovf = 1'b0; rx_abort = 1'b0;
    rx_end = 1'b1; crc_ok = crc_in;
    @(negedge clk);
    rx_end = 1'b0; crc_ok = 1'b0;
    vld = stat_vld; st = stat_byte; irq = ovf_irq;
    @(negedge clk);
    check("R2 strobe drops", int'(stat_vld), 0);
  endtask

  task automatic t_reset;
    check("R1 stat_vld", int'(stat_vld), 0);
    check("R1 stat_byte", int'(stat_byte), 0);
    check("R1 ovf_irq", int'(ovf_irq), 0);
  endtask

  task automatic t_basic;
    logic v, q; logic [7:0] s;
    set_mode(2'b11, 1'b1, 1'b0, 1'b0);
    run_frame(32, 1'b1, -1, -1, -1, v, s, q);
    check("R2 strobe", int'(v), 1);
    check("R2 status good", int'(s), 'h80);
    check("R2 no irq", int'(q), 0);
    run_frame(48, 1'b1, -1, -1, -1, v, s, q);
    check("R11 back-to-back frame", int'(v), 1);
  endtask

  task automatic t_ragged;
    logic v, q; logic [7:0] s;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0);
    run_frame(25, 1'b1, -1, -1, -1, v, s, q);
    check("R3 ragged strobe", int'(v), 1);
    check("R3 ragged status", int'(s), 'h10);
  endtask

  task automatic t_minlen(input logic off);
    logic v, q; logic [7:0] s;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++) begin
          int mn;
          set_mode(m[1:0], w[0], off, c[0]);
          mn = ref_min(m[1:0], w[0], off, c[0]);
          run_frame(mn*8, 1'b1, -1, -1, -1, v, s, q);
          check(off ? "R5 at minimum" : "R4 at minimum", int'(v), 1);
          run_frame((mn-1)*8, 1'b1, 0, -1, -1, v, s, q);
          check(off ? "R5/R6 below minimum" : "R4/R6 below minimum", int'(v), 0);
          check("R6 no irq on short frame", int'(q), 0);
        end
  endtask

  task automatic t_crc;
    logic v, q; logic [7:0] s;
    set_mode(2'b01, 1'b0, 1'b0, 1'b1);
    run_frame(40, 1'b0, -1, -1, -1, v, s, q);
    check("R7 crc fail strobe", int'(v), 1);
    check("R7 crc fail status", int'(s), 'h20);
    set_mode(2'b01, 1'b0, 1'b1, 1'b1);
    run_frame(8, 1'b0, -1, -1, -1, v, s, q);
    check("R7 crc ignored", int'(s), 'h80);
  endtask

  task automatic t_ovf;
    logic v, q; logic [7:0] s;
    set_mode(2'b10, 1'b0, 1'b0, 1'b0);
    run_frame(32, 1'b1, 5, -1, -1, v, s, q);
    check("R8 ovf status", int'(s), 'hC0);
    check("R8 ovf irq", int'(q), 1);
    @(negedge clk); rx_ovf = 1'b1;
    @(negedge clk); rx_ovf = 1'b0;
    run_frame(32, 1'b1, -1, -1, -1, v, s, q);
    check("R8 idle ovf ignored", int'(s), 'h80);
    check("R8 idle ovf no irq", int'(q), 0);
  endtask

  task automatic t_mode_hold;
    logic v, q; logic [7:0] s;
    set_mode(2'b11, 1'b0, 1'b0, 1'b0);
    run_frame(24, 1'b1, -1, 4, -1, v, s, q);
    check("R9 mode held", int'(v), 1);
    check("R9 status", int'(s), 'h80);
  endtask

  task automatic t_abort;
    logic v, q; logic [7:0] s;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0);
    run_frame(40, 1'b1, 2, -1, 20, v, s, q);
    check("R10 abort no status", int'(v), 0);
    check("R10 abort no irq", int'(q), 0);
  endtask

  task automatic t_restart;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0; rx_bit_vld = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    rx_bit_vld = 1'b0; rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0; rx_bit_vld = 1'b1;
    for (int i = 0; i < 16; i++) @(negedge clk);
    rx_bit_vld = 1'b0; rx_end = 1'b1; crc_ok = 1'b1;
    @(negedge clk); rx_end = 1'b0; crc_ok = 1'b0;
    check("R11 restart strobe", int'(stat_vld), 1);
    check("R11 restart status", int'(stat_byte), 'h80);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_start = 0; rx_bit_vld = 0; rx_end = 0; rx_abort = 0;
    rx_ovf = 0; crc_ok = 0;
    set_mode(2'b00, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ragged();
    t_minlen(1'b0);
    t_minlen(1'b1);
    t_crc();
    t_ovf();
    t_mode_hold();
    t_abort();
    t_restart();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule